// File: doc/BRIEF.md
# Dual-channel serial converter output stage

This block models the digital output side of a two-channel, 12-bit sampling converter. It runs on the serial clock and is framed by an active-low chip select. While select is low, the block counts falling edges of the serial clock. At the start of each conversion it captures one two's-complement sample per channel from a parallel stimulus port. It then shifts the samples out MSB first, after a fixed lead-in of zero bits. While select is high the block is idle and both data lines are released.

A mode input chooses how the results leave the block:

- **Dual-line mode:** channel A goes out on line A and channel B on line B, at the same time, in 16-clock conversions.
- **Single-line mode:** both results go out on line A, channel A first, in one 32-clock frame. Line B stays released.

High impedance is modelled as a per-line output enable. A low enable means the line is not driven, and the data output then reads 0.

Raising select before a conversion ends aborts it. The next low-going select starts again from the lead-in. While select stays low, conversions repeat back to back, and each one captures a fresh pair of samples. The mode input is a static setting and is changed only while select is high.

Top module: `dual_serial_adc_out`

## Requirements
- R1: While rst_ni is low, doe_a_o, doe_b_o, dout_a_o and dout_b_o are all 0.
- R2: doe_a_o is 1 exactly while cs_ni is low (and reset is released). It drops as soon as cs_ni rises, with no clock edge needed.
- R3: doe_b_o is 1 only while cs_ni is low and dual_i is 1. With dual_i at 0, line B stays released for the whole window.
- R4: Within each 16-edge conversion, the data line is 0 after falling edges 1 to 4. Sample bit 11 follows the 5th falling edge, and the bits run down to bit 0 after the 16th.
- R5: With dual_i at 1, dout_a_o carries the channel A sample and dout_b_o carries the channel B sample in the same bit positions. Conversions repeat every 16 falling edges while cs_ni stays low.
- R6: With dual_i at 0, dout_a_o carries channel A over edges 1 to 16 of a 32-edge frame and channel B over edges 17 to 32. Frames repeat while cs_ni stays low.
- R7: samp_a_i and samp_b_i are captured on the first falling edge of each conversion (dual-line mode) or frame (single-line mode). Changes at any other time have no effect on the bits shifted out.
- R8: If cs_ni rises before a conversion completes, both enables drop and the edge count is cleared. After the next fall of cs_ni, line A is enabled at 0, and the output restarts at edge 1 with the lead-in.
- R9: Samples pass through unchanged as 12-bit two's complement, MSB first. This includes 0x7FF, 0x800, 0xFFF and 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; output bits change on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select framing the conversion window |
| dual_i | input | 1 | 1: two data lines, 0: single shared line |
| samp_a_i | input | SAMPLE_W | Channel A sample, two's complement |
| samp_b_i | input | SAMPLE_W | Channel B sample, two's complement |
| dout_a_o | output | 1 | Serial data line A |
| dout_b_o | output | 1 | Serial data line B |
| doe_a_o | output | 1 | Line A drive enable (0 = high impedance) |
| doe_b_o | output | 1 | Line B drive enable (0 = high impedance) |

## Verification
The hardest cases to reach from the ports are aborts at chosen points: inside the lead-in, halfway through the payload, and inside the channel B half of a single-line frame. Each abort must be followed by a clean restart.

The stimulus opens select windows whose lengths are counted in falling edges. Some windows run exactly a whole number of conversions, and others stop part way through.

The samples change on every clock, so the reference model shows any capture at the wrong edge. Fixed corner codes are held across dedicated windows.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam int unsigned DEF_SAMPLE_W = 12;
  localparam int unsigned DEF_LEAD_W   = 4;
  localparam int unsigned NUM_LINES    = 2;

  typedef enum logic {
    LINE_A = 1'b0,
    LINE_B = 1'b1
  } line_e;
endpackage

// File: rtl/dsa_slot_counter.sv
module dsa_slot_counter #(
  parameter int unsigned CONV_LEN = 16,
  localparam int unsigned CNT_W = $clog2(2 * CONV_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             dual_i,
  output logic [CNT_W-1:0] slot_o,
  output logic             load_o
);
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] last;

  // dual-line frames are one conversion, single-line frames two
  assign last   = dual_i ? CNT_W'(CONV_LEN - 1) : CNT_W'(2 * CONV_LEN - 1);
  assign slot_o = idx_q;
  assign load_o = (idx_q == '0);

  always_ff @(negedge clk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (cs_ni) begin
      idx_q <= '0;
    end else if (idx_q == last) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dsa_sample_latch.sv
module dsa_sample_latch #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] samp_a_i,
  input  logic [SAMPLE_W-1:0] samp_b_i,
  output logic [SAMPLE_W-1:0] held_a_o,
  output logic [SAMPLE_W-1:0] held_b_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_a_o <= '0;
      held_b_o <= '0;
    end else if (!cs_ni && load_i) begin
      held_a_o <= samp_a_i;
      held_b_o <= samp_b_i;
    end
  end
endmodule

// File: rtl/dsa_serializer.sv
module dsa_serializer #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned LEAD_W   = 4,
  localparam int unsigned CONV_LEN = SAMPLE_W + LEAD_W,
  localparam int unsigned CNT_W    = $clog2(2 * CONV_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                dual_i,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    slot_i,
  input  logic [SAMPLE_W-1:0] live_first_i,
  input  logic [SAMPLE_W-1:0] live_second_i,
  input  logic [SAMPLE_W-1:0] held_first_i,
  input  logic [SAMPLE_W-1:0] held_second_i,
  output logic                bit_o
);
  logic                in_second;
  logic [CNT_W-1:0]    phase;
  logic [CNT_W-1:0]    shamt;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] shifted;
  logic                bit_d;

  always_comb begin
    in_second = !dual_i && (slot_i >= CNT_W'(CONV_LEN));
    phase     = in_second ? slot_i - CNT_W'(CONV_LEN) : slot_i;
    // bypass the latch on the load edge so a zero lead-in still works
    if (load_i) word = in_second ? live_second_i : live_first_i;
    else        word = in_second ? held_second_i : held_first_i;
    shamt   = CNT_W'(CONV_LEN - 1) - phase;
    shifted = word >> shamt;
    bit_d   = (phase < CNT_W'(LEAD_W)) ? 1'b0 : shifted[0];
  end

  always_ff @(negedge clk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni) begin
      bit_o <= 1'b0;
    end else if (cs_ni) begin
      bit_o <= 1'b0;
    end else begin
      bit_o <= bit_d;
    end
  end
endmodule

// File: rtl/dual_serial_adc_out.sv
module dual_serial_adc_out
  import dsa_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned LEAD_W   = DEF_LEAD_W,
  localparam int unsigned CONV_LEN = SAMPLE_W + LEAD_W,
  localparam int unsigned CNT_W    = $clog2(2 * CONV_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                dual_i,
  input  logic [SAMPLE_W-1:0] samp_a_i,
  input  logic [SAMPLE_W-1:0] samp_b_i,
  output logic                dout_a_o,
  output logic                dout_b_o,
  output logic                doe_a_o,
  output logic                doe_b_o
);
  logic [CNT_W-1:0]    slot;
  logic                load;
  logic [SAMPLE_W-1:0] held_a;
  logic [SAMPLE_W-1:0] held_b;

  logic [NUM_LINES-1:0][SAMPLE_W-1:0] live_first;
  logic [NUM_LINES-1:0][SAMPLE_W-1:0] live_second;
  logic [NUM_LINES-1:0][SAMPLE_W-1:0] held_first;
  logic [NUM_LINES-1:0][SAMPLE_W-1:0] held_second;
  logic [NUM_LINES-1:0]               line_bit;
  logic [NUM_LINES-1:0]               line_oe;

  dsa_slot_counter #(.CONV_LEN(CONV_LEN)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .dual_i (dual_i),
    .slot_o (slot),
    .load_o (load)
  );

  dsa_sample_latch #(.SAMPLE_W(SAMPLE_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .load_i   (load),
    .samp_a_i (samp_a_i),
    .samp_b_i (samp_b_i),
    .held_a_o (held_a),
    .held_b_o (held_b)
  );

  // line A: A then B (B used only in single-line mode); line B: B only
  assign live_first[LINE_A]  = samp_a_i;
  assign live_second[LINE_A] = samp_b_i;
  assign held_first[LINE_A]  = held_a;
  assign held_second[LINE_A] = held_b;
  assign live_first[LINE_B]  = samp_b_i;
  assign live_second[LINE_B] = samp_b_i;
  assign held_first[LINE_B]  = held_b;
  assign held_second[LINE_B] = held_b;

  assign line_oe[LINE_A] = rst_ni && !cs_ni;
  assign line_oe[LINE_B] = rst_ni && !cs_ni && dual_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    dsa_serializer #(
      .SAMPLE_W (SAMPLE_W),
      .LEAD_W   (LEAD_W)
    ) u_ser (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cs_ni         (cs_ni),
      .dual_i        (dual_i),
      .load_i        (load),
      .slot_i        (slot),
      .live_first_i  (live_first[g]),
      .live_second_i (live_second[g]),
      .held_first_i  (held_first[g]),
      .held_second_i (held_second[g]),
      .bit_o         (line_bit[g])
    );
  end

  assign dout_a_o = line_bit[LINE_A] & line_oe[LINE_A];
  assign dout_b_o = line_bit[LINE_B] & line_oe[LINE_B];
  assign doe_a_o  = line_oe[LINE_A];
  assign doe_b_o  = line_oe[LINE_B];
endmodule

// File: rtl/dsa_out_checker.sv
module dsa_out_checker #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned LEAD_W   = 4,
  localparam int unsigned CONV_LEN = SAMPLE_W + LEAD_W,
  localparam int unsigned PH_W     = $clog2(CONV_LEN)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic dual_i,
  input logic dout_a_o,
  input logic dout_b_o,
  input logic doe_a_o,
  input logic doe_b_o
);
  logic [PH_W-1:0] pos_q;
  logic            started_q;

  // falling edges seen in this window, modulo one conversion
  always_ff @(negedge clk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      started_q <= 1'b0;
    end else if (cs_ni) begin
      pos_q     <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      pos_q     <= (pos_q == PH_W'(CONV_LEN - 1)) ? '0 : pos_q + PH_W'(1);
    end
  end

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!doe_a_o && !doe_b_o && !dout_a_o && !dout_b_o);
    end
  end

  always_comb begin
    if (cs_ni) begin
      assert_deselect_release_R2: assert (!doe_a_o && !doe_b_o);
    end
  end

  assert_single_b_idle_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !dual_i |-> !doe_b_o
  );

  assert_lead_in_zero_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      (started_q && pos_q >= PH_W'(1) && pos_q <= PH_W'(LEAD_W)) |-> (!dout_a_o && !dout_b_o)
  );
endmodule

bind dual_serial_adc_out dsa_out_checker #(
  .SAMPLE_W (SAMPLE_W),
  .LEAD_W   (LEAD_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .dual_i   (dual_i),
  .dout_a_o (dout_a_o),
  .dout_b_o (dout_b_o),
  .doe_a_o  (doe_a_o),
  .doe_b_o  (doe_b_o)
);

// File: tb/dual_serial_adc_out_test.sv
`timescale 1ns/1ps
module dual_serial_adc_out_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        dual_i = 1'b1;
  logic [11:0] samp_a_i = '0;
  logic [11:0] samp_b_i = '0;
  logic        dout_a_o, dout_b_o, doe_a_o, doe_b_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit hold_samples = 0;
  bit corner_phase = 0;

  // reference model state
  int    k = 0;
  int    la = 0, lb = 0;
  int    exp_a = 0, exp_b = 0;
  string tag = "R4";

  always #10 clk_i = ~clk_i;

  dual_serial_adc_out uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .dual_i   (dual_i),
    .samp_a_i (samp_a_i),
    .samp_b_i (samp_b_i),
    .dout_a_o (dout_a_o),
    .dout_b_o (dout_b_o),
    .doe_a_o  (doe_a_o),
    .doe_b_o  (doe_b_o)
  );

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // behavioural model, advanced on each falling edge
  always @(negedge clk_i) begin
    if (!rst_ni || cs_ni) begin
      k = 0; exp_a = 0; exp_b = 0; tag = "R4";
    end else begin
      int flen, slot, ph, half, wa;
      flen = dual_i ? 16 : 32;
      slot = k % flen;
      if (slot == 0) begin la = samp_a_i; lb = samp_b_i; end
      half = slot / 16;
      ph   = slot % 16;
      wa   = (dual_i || half == 0) ? la : lb;
      if (ph < 4) begin
        exp_a = 0; exp_b = 0; tag = "R4";
      end else begin
        exp_a = (wa >> (15 - ph)) & 1;
        exp_b = (lb >> (15 - ph)) & 1;
        if (corner_phase) tag = "R9";
        else if (dual_i)  tag = "R5 R7";
        else              tag = "R6 R7";
      end
      k++;
    end
  end

  // compare on every rising edge, half a period away from the active edge
  always @(posedge clk_i) begin
    if (rst_ni && !finished) begin
      chk("R2", int'(doe_a_o), int'(!cs_ni));
      chk("R3", int'(doe_b_o), int'(!cs_ni && dual_i));
      if (!cs_ni) begin
        chk(tag, int'(dout_a_o), exp_a);
        if (dual_i) chk(tag, int'(dout_b_o), exp_b);
      end
    end
    if (!hold_samples) begin
      samp_a_i <= 12'($urandom);
      samp_b_i <= 12'($urandom);
    end
  end

  // open a window of n falling edges, then deselect
  task automatic window(int n);
    @(posedge clk_i); #2;
    cs_ni = 1'b0;
    #1;
    chk("R8", int'(doe_a_o), 1);
    chk("R8", int'(dout_a_o), 0);
    repeat (n) @(negedge clk_i);
    @(posedge clk_i); #2;
    cs_ni = 1'b1;
    #1;
    chk("R8", int'(doe_a_o), 0);
    chk("R8", int'(doe_b_o), 0);
    repeat (3) @(posedge clk_i);
  endtask

  task automatic corner(bit mode, logic [11:0] a, logic [11:0] b);
    @(posedge clk_i); #2;
    hold_samples = 1; corner_phase = 1;
    dual_i = mode; samp_a_i = a; samp_b_i = b;
    window(mode ? 32 : 64);
    hold_samples = 0; corner_phase = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #3;
    // R1: quiet during reset even with select low
    cs_ni = 1'b0;
    #1;
    chk("R1", int'(doe_a_o), 0);
    chk("R1", int'(doe_b_o), 0);
    chk("R1", int'(dout_a_o), 0);
    chk("R1", int'(dout_b_o), 0);
    cs_ni = 1'b1;
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);

    // dual-line: back-to-back conversions, aborts in lead-in and payload (R5, R8)
    dual_i = 1'b1;
    window(48);
    window(50);
    window(9);
    window(40);
    // single-line: full frames, abort inside channel B half (R6, R3)
    @(posedge clk_i); #2; dual_i = 1'b0;
    window(96);
    window(25);
    window(12);
    window(70);
    // R9: corner codes
    corner(1'b1, 12'h7FF, 12'h800);
    corner(1'b1, 12'hFFF, 12'h000);
    corner(1'b0, 12'h800, 12'h7FF);
    corner(1'b0, 12'h000, 12'hFFF);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule